// File: doc/BRIEF.md
# Byte Packer with Single-Beat Memory Write Master

This block takes a stream of 8-bit values on a simple enable/ready handshake and gathers every eight of them into one 64-bit word. Each finished word is sent to memory as a single-beat AXI4 write, using the write address, write data and write response channels. The user never gives an address. An internal write pointer starts at zero after reset and moves forward one word after every completed write.

Back-pressure on the input works as follows. A byte moves only on a clock edge where `in_en` and `in_rdy` are both high. The producer may hold `in_en` high for as long as it likes. While `in_rdy` is low, `in_data` is ignored. `in_rdy` falls after the eighth byte of a word and stays low until the memory answers on the response channel. This means one word is in flight at a time.

On the memory side, the address and data requests are raised together and each one is dropped on its own handshake. A response other than OKAY sets a sticky error flag. The pointer still advances in that case, so later words land where the stream order puts them.

Top module: `byte_pack_axiw`

## Requirements
- R1: After reset, `awaddr` is 0, `in_rdy` is 1, `awvalid`, `wvalid` and `bready` are 0, and `err_sticky` is 0.
- R2: A byte is taken only on a rising edge with `in_en`=1 and `in_rdy`=1. Bytes presented while `in_rdy`=0 do not appear in any written word.
- R3: Within a word, the first accepted byte occupies `wdata[7:0]` and the eighth occupies `wdata[63:56]`. Byte k (counting from 0) occupies `wdata[8k+7:8k]`.
- R4: Every write uses the same fixed attributes: `awlen`=0, `awsize`=3, `awburst`=2'b01 (incrementing), `wstrb`=8'hFF and `wlast`=1.
- R5: `awvalid` and `wvalid` both rise in the cycle after the eighth byte is accepted. Each stays high until its own handshake (valid and ready high at a rising edge). `awaddr` and `wdata` do not change while their valid is high.
- R6: `in_rdy` is 0 from the cycle after the eighth byte until the response handshake, and it is 1 again in the cycle after that handshake. `bready` is 1 while a write is outstanding.
- R7: `awaddr` advances by 8 in the cycle after each response handshake. Word n is written at address 8·n, so every address is 8-byte aligned.
- R8: A response handshake with `bresp` other than 2'b00 sets `err_sticky`, which then stays 1 until reset. The address still advances by 8 on that response.
- R9: Cycles with `in_en`=0 between accepted bytes do not change how the bytes are packed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_en | input | 1 | Producer offers a byte |
| in_rdy | output | 1 | Block can take a byte |
| in_data | input | 8 | Byte offered |
| awaddr | output | 32 | Write address (byte address) |
| awlen | output | 8 | Burst length minus one, always 0 |
| awsize | output | 3 | Beat size code, always 3 (8 bytes) |
| awburst | output | 2 | Burst type, always incrementing |
| awvalid | output | 1 | Address request valid |
| awready | input | 1 | Address request accepted |
| wdata | output | 64 | Packed write data |
| wstrb | output | 8 | Byte strobes, all set |
| wlast | output | 1 | Final beat marker, always 1 |
| wvalid | output | 1 | Data beat valid |
| wready | input | 1 | Data beat accepted |
| bresp | input | 2 | Write response code |
| bvalid | input | 1 | Response valid |
| bready | output | 1 | Block takes the response |
| err_sticky | output | 1 | A non-OKAY response has been seen |

## Verification
The address handshake and the data handshake can finish in the same clock edge, or either one can come first. The bench's memory model changes the `awready` and `wready` delays from word to word. The first word has both delays at zero, so both channels complete on the same edge. Later words let the address finish ahead of the data, or the data ahead of the address. In every case the scoreboard compares the captured address and data against the driver's expected word, and it checks that `in_rdy` returns only after the response handshake.

// File: rtl/byte_pack_pkg.sv
package byte_pack_pkg;
  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;

  typedef enum logic {
    WR_IDLE   = 1'b0,
    WR_ACTIVE = 1'b1
  } wr_state_e;
endpackage

// File: rtl/bp_lane_packer.sv
module bp_lane_packer #(
  parameter int IN_W   = 8,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              in_en,
  output logic              in_rdy,
  input  logic [IN_W-1:0]   in_data,
  output logic              word_done,
  output logic [DATA_W-1:0] word_out
);
  localparam int LANES = DATA_W / IN_W;
  localparam int CNT_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [CNT_W-1:0] LAST_LANE = CNT_W'(LANES - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] word_q;
  logic              take;

  assign in_rdy    = !hold;
  assign take      = in_en && in_rdy;
  assign word_done = take && (cnt_q == LAST_LANE);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign word_out[i*IN_W +: IN_W] =
      (cnt_q == CNT_W'(i)) ? in_data : word_q[i*IN_W +: IN_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      word_q <= '0;
    end else if (take) begin
      for (int i = 0; i < LANES; i++) begin
        if (cnt_q == CNT_W'(i)) word_q[i*IN_W +: IN_W] <= in_data;
      end
      cnt_q <= (cnt_q == LAST_LANE) ? '0 : cnt_q + 1'b1;
    end
  end

  // R2
  hold_freezes_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold || !in_en) |=> $stable(cnt_q));
endmodule

// File: rtl/bp_axi_wr_issue.sv
module bp_axi_wr_issue
  import byte_pack_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] start_data,
  output logic              awvalid,
  input  logic              awready,
  output logic [DATA_W-1:0] wdata,
  output logic              wvalid,
  input  logic              wready,
  input  logic [1:0]        bresp,
  input  logic              bvalid,
  output logic              bready,
  output logic              pending,
  output logic              done,
  output logic              err
);
  wr_state_e         state_q;
  logic              aw_q, w_q, err_q;
  logic [DATA_W-1:0] data_q;

  assign pending = (state_q == WR_ACTIVE);
  assign awvalid = aw_q;
  assign wvalid  = w_q;
  assign wdata   = data_q;
  assign bready  = pending;
  assign done    = bvalid && bready;
  assign err     = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WR_IDLE;
      aw_q    <= 1'b0;
      w_q     <= 1'b0;
      err_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      case (state_q)
        WR_IDLE: if (start) begin
          state_q <= WR_ACTIVE;
          aw_q    <= 1'b1;
          w_q     <= 1'b1;
          data_q  <= start_data;
        end
        WR_ACTIVE: begin
          if (aw_q && awready) aw_q <= 1'b0;
          if (w_q && wready)   w_q  <= 1'b0;
          if (done) begin
            state_q <= WR_IDLE;
            if (bresp != RESP_OKAY) err_q <= 1'b1;
          end
        end
        default: state_q <= WR_IDLE;
      endcase
    end
  end

  // R5
  w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && !wready) |=> (wvalid && $stable(wdata)));
  // R5
  aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && !awready) |=> awvalid);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R8
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && bready && bresp != RESP_OKAY) |=> err);
endmodule

// File: rtl/bp_addr_step.sv
module bp_addr_step #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr
);
  localparam int STEP  = DATA_W / 8;
  localparam int ALN_W = $clog2(STEP);

  logic [ADDR_W-1:0] addr_q;
  assign addr = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       addr_q <= '0;
    else if (advance) addr_q <= addr_q + ADDR_W'(STEP);
  end

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (addr == $past(addr) + ADDR_W'(STEP)));
  // R7
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr[ALN_W-1:0] == '0);
endmodule

// File: rtl/byte_pack_axiw.sv
module byte_pack_axiw
  import byte_pack_pkg::*;
#(
  parameter int IN_W   = 8,
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_en,
  output logic              in_rdy,
  input  logic [IN_W-1:0]   in_data,
  output logic [ADDR_W-1:0] awaddr,
  output logic [7:0]        awlen,
  output logic [2:0]        awsize,
  output logic [1:0]        awburst,
  output logic              awvalid,
  input  logic              awready,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W/8-1:0] wstrb,
  output logic              wlast,
  output logic              wvalid,
  input  logic              wready,
  input  logic [1:0]        bresp,
  input  logic              bvalid,
  output logic              bready,
  output logic              err_sticky
);
  localparam int BYTES = DATA_W / 8;

  logic              word_done, pending, wr_done;
  logic [DATA_W-1:0] word;

  assign awlen   = 8'd0;
  assign awsize  = 3'($clog2(BYTES));
  assign awburst = BURST_INCR;
  assign wstrb   = '1;
  assign wlast   = 1'b1;

  bp_lane_packer #(.IN_W(IN_W), .DATA_W(DATA_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .hold(pending),
    .in_en(in_en), .in_rdy(in_rdy), .in_data(in_data),
    .word_done(word_done), .word_out(word)
  );

  bp_axi_wr_issue #(.DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .start(word_done), .start_data(word),
    .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .pending(pending), .done(wr_done), .err(err_sticky)
  );

  bp_addr_step #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .advance(wr_done), .addr(awaddr)
  );

  // R5
  valid_pair_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(awvalid) |-> $rose(wvalid));
  // R5
  awaddr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && !awready) |=> $stable(awaddr));
  // R6
  rdy_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid || wvalid || bready) |-> !in_rdy);
  // R6
  rdy_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && bready) |=> in_rdy);
endmodule

// File: tb/byte_pack_axiw_tb.sv
module byte_pack_axiw_tb;
  localparam int WORDS = 6;
  localparam int BAD_IDX = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_en = 1'b0;
  logic        in_rdy;
  logic [7:0]  in_data = '0;
  logic [31:0] awaddr;
  logic [7:0]  awlen;
  logic [2:0]  awsize;
  logic [1:0]  awburst;
  logic        awvalid;
  logic        awready = 1'b0;
  logic [63:0] wdata;
  logic [7:0]  wstrb;
  logic        wlast;
  logic        wvalid;
  logic        wready = 1'b0;
  logic [1:0]  bresp = 2'b00;
  logic        bvalid = 1'b0;
  logic        bready;
  logic        err_sticky;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  byte_pack_axiw u_dut (
    .clk(clk), .rst_n(rst_n), .in_en(in_en), .in_rdy(in_rdy), .in_data(in_data),
    .awaddr(awaddr), .awlen(awlen), .awsize(awsize), .awburst(awburst),
    .awvalid(awvalid), .awready(awready), .wdata(wdata), .wstrb(wstrb),
    .wlast(wlast), .wvalid(wvalid), .wready(wready), .bresp(bresp),
    .bvalid(bvalid), .bready(bready), .err_sticky(err_sticky)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [31:0] exp_addr_q[$];
  logic [63:0] exp_data_q[$];

  // driver
  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_en   = 1'b1;
    in_data = b;
    while (!in_rdy) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_en = 1'b0;
    end
  endtask

  // R2: offer junk only while the block refuses bytes
  task automatic junk_while_busy(input int n);
    repeat (n) begin
      @(negedge clk);
      if (!in_rdy) begin in_en = 1'b1; in_data = 8'hEE; end
      else in_en = 1'b0;
    end
    @(negedge clk);
    in_en = 1'b0;
  endtask

  task automatic send_word(input int k, input int gap);
    logic [63:0] w;
    w = '0;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] b;
      b = 8'(k * 37 + i * 11 + 8'h21);
      w[i*8 +: 8] = b;
      send_byte(b);
      if (gap > 0 && i < 7) idle(gap);
    end
    exp_addr_q.push_back(32'(k * 8));
    exp_data_q.push_back(w);
    junk_while_busy(4);
  endtask

  // memory model
  int   n_done = 0;
  bit   got_aw = 0, got_w = 0, b_done = 0, prev_awv = 0;
  int   aw_cnt = 0, w_cnt = 0, b_cnt = 0;
  logic [31:0] cap_addr;
  logic [63:0] cap_data;

  always @(posedge clk) begin
    if (rst_n) begin
      if (awvalid && awready) begin
        got_aw = 1; cap_addr = awaddr;
        // R4
        check(awlen == 8'd0 && awsize == 3'd3 && awburst == 2'b01, "R4 aw attrs",
              {51'd0, awlen, awsize, awburst}, {51'd0, 8'd0, 3'd3, 2'b01});
      end
      if (wvalid && wready) begin
        got_w = 1; cap_data = wdata;
        // R4
        check(wstrb == 8'hFF && wlast, "R4 w attrs", {55'd0, wstrb, wlast},
              {55'd0, 8'hFF, 1'b1});
      end
      if (bvalid && bready) begin
        logic [31:0] ea;
        logic [63:0] ed;
        if (exp_addr_q.size() == 0) begin
          check(0, "R2 unexpected write", 64'(cap_addr), 64'd0);
        end else begin
          ea = exp_addr_q.pop_front();
          ed = exp_data_q.pop_front();
          // R7
          check(cap_addr == ea, "R7 address", 64'(cap_addr), 64'(ea));
          // R3 / R9 / R2
          check(cap_data == ed, "R3 packed data", cap_data, ed);
        end
        // R8
        check(err_sticky == (n_done > BAD_IDX), "R8 err before resp",
              64'(err_sticky), 64'(n_done > BAD_IDX));
        n_done++;
        got_aw = 0; got_w = 0; b_done = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      awready = 0; wready = 0; bvalid = 0; bresp = 0;
    end else begin
      // R5
      if (awvalid && !prev_awv)
        check(wvalid == 1'b1, "R5 valids together", 64'(wvalid), 64'd1);
      prev_awv = awvalid;
      // R6
      if (awvalid || wvalid)
        check(!in_rdy && bready, "R6 busy handshake", {62'd0, in_rdy, bready},
              {62'd0, 1'b0, 1'b1});
      awready = awvalid && !got_aw && (aw_cnt >= (n_done % 3));
      if (awvalid && !got_aw) aw_cnt++;
      wready = wvalid && !got_w && (w_cnt >= ((n_done * 2) % 3));
      if (wvalid && !got_w) w_cnt++;
      if (b_done) begin
        // R6
        check(in_rdy == 1'b1, "R6 ready after resp", 64'(in_rdy), 64'd1);
        // R7
        check(awaddr == 32'(n_done * 8), "R7 step", 64'(awaddr), 64'(n_done * 8));
        bvalid = 0; bresp = 0; b_done = 0;
        aw_cnt = 0; w_cnt = 0; b_cnt = 0;
      end else if (got_aw && got_w && !bvalid) begin
        if (b_cnt >= (n_done % 2)) begin
          bvalid = 1;
          bresp  = (n_done == BAD_IDX) ? 2'b10 : 2'b00;
        end else b_cnt++;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check(awaddr == 0 && in_rdy && !awvalid && !wvalid && !bready && !err_sticky,
          "R1 reset", {58'd0, awaddr == 0, in_rdy, awvalid, wvalid, bready, err_sticky},
          {58'd0, 6'b110000});
    rst_n = 1'b1;
    @(negedge clk);
    check(awaddr == 0 && in_rdy, "R1 after release", {62'd0, awaddr == 0, in_rdy},
          {62'd0, 2'b11});
    for (int k = 0; k < WORDS; k++) begin
      // R9: words 2 and 4 carry idle cycles between bytes
      send_word(k, (k == 2) ? 2 : ((k == 4) ? 1 : 0));
    end
    while (n_done < WORDS) @(negedge clk);
    repeat (2) @(negedge clk);
    // R8
    check(err_sticky == 1'b1, "R8 sticky at end", 64'(err_sticky), 64'd1);
    // R7
    check(awaddr == 32'(WORDS * 8), "R7 final address", 64'(awaddr), 64'(WORDS * 8));
    check(!awvalid && !wvalid && in_rdy, "R2 no stray write",
          {61'd0, awvalid, wvalid, in_rdy}, {61'd0, 3'b001});
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule